// File: doc/BRIEF.md
# Interrupt Redirection Register File with Select/Window Access

This block holds the programmable state of an I/O interrupt controller and exposes it through two bus-visible registers. Software first writes a select register with the number of the internal register it wants, then reads or writes a 32-bit data window to reach it. The internal space has a version register, an identification register, an arbitration register and one 64-bit redirection entry per interrupt pin. Each entry is reached as two 32-bit halves.

Writes to an entry produce single-cycle side-effect strobes for the servicing logic next to the block. One strobe reports that a pin's mask bit changed. The other asks for a level-triggered pin with a pending request to be serviced again. The servicing logic sets an entry's remote-IRR flag through a dedicated input. A write to the entry's low half clears that flag again. The bus port has no handshake: a qualified access is claimed, and a read is answered, one cycle after it is presented.

Top module: `intc_window_regs`

## Requirements
- R1: With select value 0x00, a window read returns 0x00170011: the pin count minus one (23) in bits 23:16 and version 0x11 in bits 7:0. Window writes with this select value change nothing.
- R2: With select value 0x01, a window write stores data bits 27:24 as a 4-bit ID. Window reads with select 0x01 or 0x02 return that ID in bits 27:24 and zero elsewhere. Window writes with select 0x02 change nothing.
- R3: The select register sits at byte offset 0x00 and the window at offset 0x10. A select read returns the last value written. For select values of 0x10 and above, the entry index is (select − 0x10) >> 1. An even select value reaches bits 31:0 of the entry and an odd value reaches bits 63:32.
- R4: A window write whose entry index is 24 or more changes no state and raises no strobe. A window read of such an index, or of select 0x03 to 0x0F, returns 0.
- R5: Writing an entry's low half clears its remote-IRR flag, which reads back in bit 14 of the low half. Writing the high half leaves the flag unchanged. If a set and a low-half write hit the same entry in the same cycle, the clear wins.
- R6: When an entry write changes the entry's mask bit (bit 16 of the low half), mask_chg_valid pulses for one cycle, one cycle after the write. The pulse carries the pin index and the new mask value. A write that leaves the mask bit unchanged raises no pulse.
- R7: After an entry write, resvc_valid pulses for one cycle with the pin index if two conditions hold: the entry is level-triggered (bit 15 of the low half is 1) and pin_req for that pin is 1. No pulse is raised for an edge-triggered entry or when pin_req is 0.
- R8: Reset sets every entry's mask bit, clears the select register, the ID, all remote-IRR flags and the remaining entry bits, and drives every strobe low.
- R9: Writes with bus_len other than 4 or 8 (bytes) are ignored. Writes with length 4 or 8 use bus_wdata.
- R10: Reads of byte offsets other than 0x00 and 0x10 inside the 256-byte region at BASE return 0. Accesses outside the region are not claimed and produce no read response.
- R11: A pulse on rirr_set with a pin index below 24 sets that entry's remote-IRR flag.
- R12: Every in-range access raises bus_claim one cycle later. An in-range read also raises bus_rvalid with its data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| pin_req | input | 24 | Pending request bit per pin, from the servicing logic |
| rirr_set | input | 1 | Set remote-IRR for rirr_pin |
| rirr_pin | input | 5 | Pin index for rirr_set |
| bus_claim | output | 1 | Previous-cycle access was in range |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| mask_chg_valid | output | 1 | Mask bit of an entry changed |
| mask_chg_pin | output | 5 | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| resvc_valid | output | 1 | Re-service request |
| resvc_pin | output | 5 | Pin to re-service |

## Verification
The assertions take for granted that rst is held for at least one clock before use. They also assume that every input is stable across the sampling edge. A strobe is traced to the write one cycle earlier, so inputs must never change more than once per cycle. The bench drives each access for exactly one cycle on the falling edge, with at least one idle cycle between accesses. It pulses rirr_set only in cycles with no bus access, and it only ever uses pin indices below 24 on rirr_pin.

// File: rtl/intc_win_pkg.sv
package intc_win_pkg;
  localparam int DATA_W   = 32;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [DATA_W-1:0] SEL_VERSION = 32'h0;
  localparam logic [DATA_W-1:0] SEL_IDENT   = 32'h1;
  localparam logic [DATA_W-1:0] SEL_ARB     = 32'h2;
  localparam logic [DATA_W-1:0] SEL_ENTRY0  = 32'h10;

  typedef enum logic [1:0] {
    KIND_SELECT,
    KIND_WINDOW,
    KIND_OTHER
  } reg_kind_e;
endpackage

// File: rtl/win_bus_decode.sv
module win_bus_decode
  import intc_win_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] BASE   = 32'hFEC0_0000,
  parameter int          OFS_W  = 8
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        len,
  output logic              hit,
  output logic              wr_fire,
  output reg_kind_e         kind
);
  localparam logic [ADDR_W:0] LO   = {1'b0, BASE[ADDR_W-1:0]};
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(1) << OFS_W;

  logic       in_range;
  logic [7:0] ofs;

  always_comb begin
    in_range = ({1'b0, addr} >= LO) && ({1'b0, addr} < LO + SPAN);
    hit      = valid && in_range;
    wr_fire  = hit && write && ((len == 4'd4) || (len == 4'd8));
    ofs      = 8'(addr[OFS_W-1:0]);
    if (ofs == OFS_SELECT)      kind = KIND_SELECT;
    else if (ofs == OFS_WINDOW) kind = KIND_WINDOW;
    else                        kind = KIND_OTHER;
  end
endmodule

// File: rtl/redir_table.sv
module redir_table
  import intc_win_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PIN_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [PIN_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIN_W-1:0]  rd_idx,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pin_req,
  input  logic              rirr_set,
  input  logic [PIN_W-1:0]  rirr_pin,
  output logic              mask_chg_valid,
  output logic [PIN_W-1:0]  mask_chg_pin,
  output logic              mask_chg_val,
  output logic              resvc_valid,
  output logic [PIN_W-1:0]  resvc_pin
);
  logic [DATA_W-1:0] lo_q [NPINS];
  logic [DATA_W-1:0] hi_q [NPINS];
  logic [NPINS-1:0]  mask_q;
  logic [NPINS-1:0]  rirr_q;

  logic new_mask, new_trig;

  always_comb begin
    new_mask = wr_hi ? mask_q[wr_idx] : wr_data[MASK_BIT];
    new_trig = wr_hi ? lo_q[wr_idx][TRIG_BIT] : wr_data[TRIG_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
      mask_q         <= '1;
      rirr_q         <= '0;
      mask_chg_valid <= 1'b0;
      mask_chg_pin   <= '0;
      mask_chg_val   <= 1'b0;
      resvc_valid    <= 1'b0;
      resvc_pin      <= '0;
    end else begin
      mask_chg_valid <= 1'b0;
      resvc_valid    <= 1'b0;
      if (rirr_set && (32'(rirr_pin) < NPINS)) rirr_q[rirr_pin] <= 1'b1;
      if (wr_en) begin
        if (wr_hi) begin
          hi_q[wr_idx] <= wr_data;
        end else begin
          lo_q[wr_idx]   <= wr_data;
          mask_q[wr_idx] <= wr_data[MASK_BIT];
          rirr_q[wr_idx] <= 1'b0;
        end
        if (new_mask != mask_q[wr_idx]) begin
          mask_chg_valid <= 1'b1;
          mask_chg_pin   <= wr_idx;
          mask_chg_val   <= new_mask;
        end
        if (new_trig && pin_req[wr_idx]) begin
          resvc_valid <= 1'b1;
          resvc_pin   <= wr_idx;
        end
      end
    end
  end

  always_comb begin
    if (rd_hi) begin
      rd_data = hi_q[rd_idx];
    end else begin
      rd_data           = lo_q[rd_idx];
      rd_data[MASK_BIT] = mask_q[rd_idx];
      rd_data[RIRR_BIT] = rirr_q[rd_idx];
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R8
  always_ff @(posedge clk) begin
    if (!rst && rst_d) begin
      reset_mask_chk: assert (&mask_q && rirr_q == '0 && !mask_chg_valid && !resvc_valid);
    end
  end

  // R6
  mask_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    mask_chg_valid |-> !$past(rst) && $past(wr_en && !wr_hi));

  // R7
  resvc_src_chk: assert property (@(posedge clk) disable iff (rst)
    resvc_valid |-> !$past(rst) && $past(wr_en));

  // R5
  rirr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !wr_hi) && !$past(rst)) |-> !rirr_q[$past(wr_idx)]);
endmodule

// File: rtl/intc_window_regs.sv
module intc_window_regs
  import intc_win_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] BASE    = 32'hFEC0_0000,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int         PIN_W   = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_len,
  input  logic [31:0]       bus_wdata,
  input  logic [NPINS-1:0]  pin_req,
  input  logic              rirr_set,
  input  logic [PIN_W-1:0]  rirr_pin,
  output logic              bus_claim,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              mask_chg_valid,
  output logic [PIN_W-1:0]  mask_chg_pin,
  output logic              mask_chg_val,
  output logic              resvc_valid,
  output logic [PIN_W-1:0]  resvc_pin
);
  localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  logic      hit, wr_fire;
  reg_kind_e kind;

  win_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .OFS_W(8)) u_dec (
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .len    (bus_len),
    .hit    (hit),
    .wr_fire(wr_fire),
    .kind   (kind)
  );

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic        win_wr;
  logic        sel_entry, ent_ok;
  logic [31:0] ent_off;
  logic [30:0] ent_idx_full;
  logic [PIN_W-1:0] ent_idx;
  logic [31:0] tbl_rd;
  logic [31:0] rd_mux;

  always_comb begin
    win_wr       = wr_fire && (kind == KIND_WINDOW);
    sel_entry    = sel_q >= SEL_ENTRY0;
    ent_off      = sel_q - SEL_ENTRY0;
    ent_idx_full = ent_off[31:1];
    ent_ok       = sel_entry && (ent_idx_full < 31'(NPINS));
    ent_idx      = ent_idx_full[PIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_fire && kind == KIND_SELECT) sel_q <= bus_wdata;
      if (win_wr && sel_q == SEL_IDENT)   id_q  <= bus_wdata[27:24];
    end
  end

  redir_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tbl (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (win_wr && ent_ok),
    .wr_hi         (ent_off[0]),
    .wr_idx        (ent_idx),
    .wr_data       (bus_wdata),
    .rd_idx        (ent_idx),
    .rd_hi         (ent_off[0]),
    .rd_data       (tbl_rd),
    .pin_req       (pin_req),
    .rirr_set      (rirr_set),
    .rirr_pin      (rirr_pin),
    .mask_chg_valid(mask_chg_valid),
    .mask_chg_pin  (mask_chg_pin),
    .mask_chg_val  (mask_chg_val),
    .resvc_valid   (resvc_valid),
    .resvc_pin     (resvc_pin)
  );

  always_comb begin
    rd_mux = '0;
    if (kind == KIND_SELECT) begin
      rd_mux = sel_q;
    end else if (kind == KIND_WINDOW) begin
      if (sel_q == SEL_VERSION)                       rd_mux = VERSION_WORD;
      else if (sel_q == SEL_IDENT || sel_q == SEL_ARB) rd_mux = {4'h0, id_q, 24'h0};
      else if (ent_ok)                                rd_mux = tbl_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_claim  <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_claim  <= hit;
      bus_rvalid <= hit && !bus_write;
      if (hit && !bus_write) bus_rdata <= rd_mux;
    end
  end

  // R2
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(win_wr && sel_q == SEL_IDENT)) |-> $stable(id_q));

  // R10
  claim_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_claim |-> $past(bus_valid));

  // R12
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> bus_claim && $past(bus_valid && !bus_write));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_fire && kind == KIND_SELECT)) |-> $stable(sel_q));
endmodule

// File: tb/intc_window_regs_bench.sv
module intc_window_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFEC0_0000;
  localparam logic [31:0] SELA = BASE + 32'h00;
  localparam logic [31:0] WINA = BASE + 32'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_len = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic [23:0] pin_req = '0;
  logic        rirr_set = 1'b0;
  logic [4:0]  rirr_pin = '0;
  logic        bus_claim, bus_rvalid, mask_chg_valid, mask_chg_val, resvc_valid;
  logic [31:0] bus_rdata;
  logic [4:0]  mask_chg_pin, resvc_pin;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_window_regs u_intc_window_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .pin_req(pin_req), .rirr_set(rirr_set), .rirr_pin(rirr_pin),
    .bus_claim(bus_claim), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
    .mask_chg_val(mask_chg_val), .resvc_valid(resvc_valid), .resvc_pin(resvc_pin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected read response", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_op(input logic wr, input logic [31:0] a, input logic [3:0] l,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_len = l; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    bus_op(1'b1, a, 4'd4, d);
  endtask

  task automatic rd_exp(input logic [31:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_op(1'b0, a, 4'd4, 32'h0);
    check({tag, " claim"}, 32'(bus_claim), 32'h1);
  endtask

  task automatic win_rd(input logic [31:0] sel, input logic [31:0] exp, input string tag);
    wr32(SELA, sel);
    rd_exp(WINA, exp, tag);
  endtask

  task automatic win_wr(input logic [31:0] sel, input logic [31:0] d);
    wr32(SELA, sel);
    wr32(WINA, d);
  endtask

  task automatic strobes(input string tag, input logic mv, input logic [4:0] mp,
                         input logic mval, input logic rv, input logic [4:0] rp);
    check({tag, " mask_chg_valid"}, 32'(mask_chg_valid), 32'(mv));
    if (mv) begin
      check({tag, " mask_chg_pin"}, 32'(mask_chg_pin), 32'(mp));
      check({tag, " mask_chg_val"}, 32'(mask_chg_val), 32'(mval));
    end
    check({tag, " resvc_valid"}, 32'(resvc_valid), 32'(rv));
    if (rv) check({tag, " resvc_pin"}, 32'(resvc_pin), 32'(rp));
  endtask

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk);
    check("watchdog timeout", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 claim after reset", 32'(bus_claim), 32'h0);
    strobes("R8 strobes after reset", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    rd_exp(SELA, 32'h0, "R8 select cleared");
    rd_exp(WINA, 32'h0017_0011, "R8 select 0 is version");
    win_rd(32'h1, 32'h0, "R8 id cleared");
    win_rd(32'h10, 32'h0001_0000, "R8 entry0 masked");
    win_rd(32'h3E, 32'h0001_0000, "R8 entry23 masked");
    win_rd(32'h11, 32'h0, "R8 entry0 high zero");

    // R1 version
    win_wr(32'h0, 32'hFFFF_FFFF);
    rd_exp(WINA, 32'h0017_0011, "R1 version after write");

    // R2 ID and arbitration
    win_wr(32'h1, 32'hA500_0000);
    rd_exp(WINA, 32'h0500_0000, "R2 id read");
    win_rd(32'h2, 32'h0500_0000, "R2 arb read");
    win_wr(32'h2, 32'h0F00_0000);
    win_rd(32'h1, 32'h0500_0000, "R2 arb write ignored");

    // R3 index mapping and halves, R6 mask change
    win_wr(32'h13, 32'hCAFE_BABE);
    strobes("R6 high write no mask pulse", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    win_wr(32'h12, 32'h0000_0031);
    strobes("R6 unmask pin1", 1'b1, 5'd1, 1'b0, 1'b0, 5'd0);
    rd_exp(SELA, 32'h12, "R3 select readback");
    rd_exp(WINA, 32'h0000_0031, "R3 entry1 low");
    win_rd(32'h13, 32'hCAFE_BABE, "R3 entry1 high");
    win_rd(32'h10, 32'h0001_0000, "R3 entry0 untouched");
    win_wr(32'h12, 32'h0000_0032);
    strobes("R6 no change no pulse", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    win_wr(32'h12, 32'h0001_0032);
    strobes("R6 mask pin1", 1'b1, 5'd1, 1'b1, 1'b0, 5'd0);

    // R7 re-service
    pin_req = 24'h000030;
    win_wr(32'h18, 32'h0000_8040);
    strobes("R7 level low write", 1'b1, 5'd4, 1'b0, 1'b1, 5'd4);
    win_wr(32'h19, 32'h1100_0000);
    strobes("R7 level high write", 1'b0, 5'd0, 1'b0, 1'b1, 5'd4);
    pin_req = 24'h000020;
    win_wr(32'h19, 32'h2200_0000);
    strobes("R7 no request", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    win_wr(32'h1A, 32'h0000_0040);
    strobes("R7 edge entry", 1'b1, 5'd5, 1'b0, 1'b0, 5'd0);
    pin_req = '0;

    // R11 and R5 remote-IRR
    @(negedge clk);
    rirr_set = 1'b1; rirr_pin = 5'd4;
    @(negedge clk);
    rirr_set = 1'b0;
    win_rd(32'h18, 32'h0000_C040, "R11 rirr set");
    win_wr(32'h19, 32'h3300_0000);
    win_rd(32'h18, 32'h0000_C040, "R5 high write keeps rirr");
    win_wr(32'h18, 32'h0000_8040);
    rd_exp(WINA, 32'h0000_8040, "R5 low write clears rirr");

    // R4 out-of-range index
    win_wr(32'h40, 32'h1234_5678);
    strobes("R4 no strobes", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    rd_exp(WINA, 32'h0, "R4 read idx24");
    win_wr(32'h41, 32'h8765_4321);
    win_rd(32'h3E, 32'h0001_0000, "R4 entry23 low intact");
    win_rd(32'h3F, 32'h0, "R4 entry23 high intact");
    win_rd(32'h05, 32'h0, "R4 reserved select");

    // R9 length filter
    wr32(SELA, 32'h12);
    bus_op(1'b1, WINA, 4'd2, 32'h0);
    strobes("R9 short write ignored", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    rd_exp(WINA, 32'h0001_0032, "R9 short write no change");
    bus_op(1'b1, WINA, 4'd8, 32'h0000_0077);
    strobes("R9 len8 write", 1'b1, 5'd1, 1'b0, 1'b0, 5'd0);
    rd_exp(WINA, 32'h0000_0077, "R9 len8 data");

    // R10 decode
    rd_exp(BASE + 32'h20, 32'h0, "R10 other offset");
    bus_op(1'b0, BASE + 32'h100, 4'd4, 32'h0);
    check("R10 out of range not claimed", 32'(bus_claim), 32'h0);
    check("R10 out of range no response", 32'(bus_rvalid), 32'h0);
    bus_op(1'b1, BASE + 32'h100, 4'd4, 32'h55);
    check("R10 out of range write not claimed", 32'(bus_claim), 32'h0);
    rd_exp(SELA, 32'h12, "R10 out of range write ignored");

    repeat (3) @(negedge clk);
    check("R12 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule